// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache with Selectable Victim Policy

This block sits between a CPU load port and a slower word-wide memory. Each request carries a 32-bit byte address. The address is cut into a tag, a set number and a byte offset. The valid bit and stored tag of all four ways in the addressed set are compared at the same time. Each way holds one 32-bit word. On a hit the word is steered out through a multiplexer that is selected by the hit vector, so the requester sees its data one cycle after the request is taken.

On a miss the block picks a way to overwrite and holds a memory request until the memory answers. It then writes the returned word into that way and hands the word to the requester on the next cycle. A build-time parameter selects how the way is chosen: a pseudo-random generator, true least-recently-used order, or first-in-first-out order. A synchronous flush input empties the whole cache and puts the replacement state back to its starting values.

Only one request is in flight at a time. While a miss is pending the block reports itself busy and ignores new requests.

Top module: `assoc_rd_cache`

## Requirements
- R1: A request address splits as tag = addr[31:10], set = addr[9:2], and byte offset = addr[1:0]. The offset has no effect on hit, data or refill.
- R2: A request taken while idle that hits returns cpu_rvalid=1, cpu_hit=1 and the stored word in the next cycle, with no memory request.
- R3: A request taken while idle that misses raises mem_req and cpu_busy in the next cycle, with mem_addr = addr[31:2]. Both stay steady until mem_valid is seen. In the cycle after mem_valid the block returns cpu_rvalid=1, cpu_hit=0 and mem_rdata, and drops mem_req and cpu_busy.
- R4: At most one way of a set matches a request, so the returned word is the word of exactly that way.
- R5: On a miss, if the set holds any invalid way, the lowest-numbered invalid way is refilled, whatever the policy.
- R6: With POLICY=REPL_LRU and a full set, the refilled way is the one whose last hit or refill is oldest. After reset or flush the order from most to least recent is way 0, 1, 2, 3.
- R7: With POLICY=REPL_FIFO and a full set, the refilled way is the one refilled earliest. Hits do not change this order.
- R8: With POLICY=REPL_RANDOM and a full set, the refilled way is bits [1:0] of a 16-bit shift register. The register loads 16'hACE1 at reset and on flush. In every other cycle it becomes {r[14:0], r[15]^r[13]^r[12]^r[10]}. The value sampled is the one held in the cycle the miss is taken.
- R9: When flush is high at a clock edge, every way becomes invalid, the replacement state returns to its reset values, and any pending miss is dropped with no response. A request presented in that same cycle is not taken.
- R10: While cpu_busy is 1, cpu_req is ignored. It produces no response, no refill and no change in replacement order.
- R11: After reset, cpu_rvalid, cpu_hit, mem_req and cpu_busy are 0, and every way is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous invalidate of all ways and replacement state |
| cpu_req | input | 1 | Read request strobe, taken when cpu_busy is 0 |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_busy | output | 1 | A miss is pending; requests are ignored |
| cpu_rvalid | output | 1 | One-cycle response strobe |
| cpu_hit | output | 1 | Response came from the cache (1) or from memory (0) |
| cpu_rdata | output | 32 | Response word |
| mem_req | output | 1 | Refill request, held until mem_valid |
| mem_addr | output | 30 | Word address of the refill |
| mem_valid | input | 1 | Memory returns the refill word this cycle |
| mem_rdata | input | 32 | Refill word |

## Verification
Two events can land on the same clock edge: the memory answering a pending miss and the flush input clearing the cache. The bench raises mem_valid and flush together while a miss is open. It then expects no response in the following cycle and no refill, which it judges by the miss that a repeat of the same address must produce. A request held high while a miss is pending, and a request raised together with flush, are judged the same way. Three instances, one per replacement policy, run identical traffic. Each is compared on every clock against a behavioural model built from recency and fill-order queues and a copy of the specified shift-register sequence.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [1:0] {
        REPL_RANDOM = 2'd0,
        REPL_LRU    = 2'd1,
        REPL_FIFO   = 2'd2
    } repl_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    // Fibonacci shift, taps 16/14/13/11
    function automatic logic [15:0] lfsr_next(input logic [15:0] r);
        return {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
    endfunction

endpackage

// File: rtl/cache_way_bank.sv
module cache_way_bank #(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              hit_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [DATA_W-1:0] data_mem [SETS];
    logic [SETS-1:0]   valid_d, valid_q;

    always_comb begin
        valid_d = valid_q;
        if (flush) begin
            valid_d = '0;
        end else if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    // tag compare and data read run side by side
    assign valid_o   = valid_q[rd_idx];
    assign hit_o     = valid_o && (tag_mem[rd_idx] == rd_tag);
    assign rd_data_o = data_mem[rd_idx];

endmodule

// File: rtl/cache_repl.sv
module cache_repl #(
    parameter int               WAYS   = 4,
    parameter int               IDX_W  = 8,
    parameter cache_pkg::repl_e POLICY = cache_pkg::REPL_LRU,
    localparam int              WAY_W  = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [WAYS-1:0]  look_valid,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [WAY_W-1:0] touch_way,
    input  logic             fill_en,
    output logic [WAY_W-1:0] victim_o
);
    localparam int SETS = 1 << IDX_W;

    logic [WAY_W-1:0] policy_way;
    logic [WAY_W-1:0] inv_way;
    logic             any_inv;

    // lowest-numbered empty way wins over every policy
    always_comb begin
        inv_way = '0;
        any_inv = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!look_valid[w]) begin
                inv_way = WAY_W'(w);
                any_inv = 1'b1;
            end
        end
    end

    assign victim_o = any_inv ? inv_way : policy_way;

    generate
        if (POLICY == cache_pkg::REPL_RANDOM) begin : g_rand
            logic [15:0] lfsr_d, lfsr_q;
            logic        unused_rand;

            assign unused_rand = ^{look_idx, touch_en, touch_idx, touch_way, fill_en};
            assign lfsr_d      = flush ? cache_pkg::LFSR_SEED : cache_pkg::lfsr_next(lfsr_q);
            assign policy_way  = lfsr_q[WAY_W-1:0];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lfsr_q <= cache_pkg::LFSR_SEED;
                else        lfsr_q <= lfsr_d;
            end
        end else if (POLICY == cache_pkg::REPL_LRU) begin : g_lru
            logic [WAY_W-1:0] age_d [SETS][WAYS];
            logic [WAY_W-1:0] age_q [SETS][WAYS];
            logic [WAY_W-1:0] old_age;
            logic             unused_lru;

            assign unused_lru = fill_en;
            assign old_age    = age_q[touch_idx][touch_way];

            always_comb begin
                age_d = age_q;
                if (flush) begin
                    for (int s = 0; s < SETS; s++)
                        for (int w = 0; w < WAYS; w++)
                            age_d[s][w] = WAY_W'(w);
                end else if (touch_en) begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (WAY_W'(w) == touch_way)
                            age_d[touch_idx][w] = '0;
                        else if (age_q[touch_idx][w] < old_age)
                            age_d[touch_idx][w] = age_q[touch_idx][w] + 1'b1;
                    end
                end
            end

            always_comb begin
                policy_way = '0;
                for (int w = 0; w < WAYS; w++)
                    if (age_q[look_idx][w] == WAY_W'(WAYS - 1))
                        policy_way = WAY_W'(w);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int s = 0; s < SETS; s++)
                        for (int w = 0; w < WAYS; w++)
                            age_q[s][w] <= WAY_W'(w);
                end else begin
                    age_q <= age_d;
                end
            end
        end else begin : g_fifo
            logic [WAY_W-1:0] ptr_d [SETS];
            logic [WAY_W-1:0] ptr_q [SETS];
            logic             unused_fifo;

            assign unused_fifo = ^{touch_en, touch_way};
            assign policy_way  = ptr_q[look_idx];

            always_comb begin
                ptr_d = ptr_q;
                if (flush) begin
                    for (int s = 0; s < SETS; s++) ptr_d[s] = '0;
                end else if (fill_en) begin
                    ptr_d[touch_idx] = ptr_q[touch_idx] + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
                end else begin
                    ptr_q <= ptr_d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/assoc_rd_cache.sv
module assoc_rd_cache #(
    parameter int               ADDR_W  = 32,
    parameter int               DATA_W  = 32,
    parameter int               WAYS    = 4,
    parameter int               IDX_W   = 8,
    parameter int               OFF_W   = 2,
    parameter cache_pkg::repl_e POLICY  = cache_pkg::REPL_LRU,
    localparam int              WADDR_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               cpu_req,
    input  logic [ADDR_W-1:0]  cpu_addr,
    output logic               cpu_busy,
    output logic               cpu_rvalid,
    output logic               cpu_hit,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               mem_req,
    output logic [WADDR_W-1:0] mem_addr,
    input  logic               mem_valid,
    input  logic [DATA_W-1:0]  mem_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic               fetch;
        logic [WADDR_W-1:0] waddr;
        logic [WAY_W-1:0]   victim;
        logic               rvalid;
        logic               hit;
        logic [DATA_W-1:0]  rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic              unused_off;
    logic [WAYS-1:0]   hit_vec;
    logic [WAYS-1:0]   valid_vec;
    logic [DATA_W-1:0] way_data [WAYS];
    logic [DATA_W-1:0] hit_data;
    logic [WAY_W-1:0]  hit_way;
    logic              hit_any;
    logic              accept;
    logic              fill;
    logic [WAY_W-1:0]  victim_w;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;

    assign req_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx    = cpu_addr[OFF_W +: IDX_W];
    assign unused_off = ^cpu_addr[OFF_W-1:0];
    assign fill_idx   = ctl_q.waddr[IDX_W-1:0];
    assign fill_tag   = ctl_q.waddr[WADDR_W-1 -: TAG_W];

    assign accept = cpu_req && !ctl_q.fetch && !flush;
    assign fill   = ctl_q.fetch && mem_valid && !flush;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            cache_way_bank #(
                .IDX_W (IDX_W),
                .TAG_W (TAG_W),
                .DATA_W(DATA_W)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .flush    (flush),
                .rd_idx   (req_idx),
                .rd_tag   (req_tag),
                .hit_o    (hit_vec[w]),
                .valid_o  (valid_vec[w]),
                .rd_data_o(way_data[w]),
                .wr_en    (fill && (ctl_q.victim == WAY_W'(w))),
                .wr_idx   (fill_idx),
                .wr_tag   (fill_tag),
                .wr_data  (mem_rdata)
            );
        end
    endgenerate

    // one-hot AND-OR way select
    always_comb begin
        hit_data = '0;
        hit_way  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_data = hit_data | way_data[w];
                hit_way  = hit_way  | WAY_W'(w);
            end
        end
    end

    assign hit_any = |hit_vec;

    cache_repl #(
        .WAYS  (WAYS),
        .IDX_W (IDX_W),
        .POLICY(POLICY)
    ) u_repl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .look_idx  (req_idx),
        .look_valid(valid_vec),
        .touch_en  (fill || (accept && hit_any)),
        .touch_idx (fill ? fill_idx : req_idx),
        .touch_way (fill ? ctl_q.victim : hit_way),
        .fill_en   (fill),
        .victim_o  (victim_w)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = 1'b0;
        if (flush) begin
            ctl_d.fetch = 1'b0;
        end else if (fill) begin
            ctl_d.fetch  = 1'b0;
            ctl_d.rvalid = 1'b1;
            ctl_d.hit    = 1'b0;
            ctl_d.rdata  = mem_rdata;
        end else if (accept) begin
            if (hit_any) begin
                ctl_d.rvalid = 1'b1;
                ctl_d.hit    = 1'b1;
                ctl_d.rdata  = hit_data;
            end else begin
                ctl_d.fetch  = 1'b1;
                ctl_d.hit    = 1'b0;
                ctl_d.waddr  = cpu_addr[ADDR_W-1:OFF_W];
                ctl_d.victim = victim_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cpu_busy   = ctl_q.fetch;
    assign cpu_rvalid = ctl_q.rvalid;
    assign cpu_hit    = ctl_q.rvalid && ctl_q.hit;
    assign cpu_rdata  = ctl_q.rdata;
    assign mem_req    = ctl_q.fetch;
    assign mem_addr   = ctl_q.waddr;

endmodule

// File: rtl/assoc_rd_cache_chk.sv
module assoc_rd_cache_chk #(
    parameter int WAYS    = 4,
    parameter int WADDR_W = 30
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               cpu_req,
    input logic               cpu_busy,
    input logic               cpu_rvalid,
    input logic               cpu_hit,
    input logic               mem_req,
    input logic               mem_valid,
    input logic [WADDR_W-1:0] mem_addr,
    input logic [WAYS-1:0]    hit_vec
);

    p_one_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_hit_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_busy && !flush && (|hit_vec) |=> cpu_rvalid && cpu_hit);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid && !flush |=> mem_req && $stable(mem_addr));

    p_fill_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_valid && !flush |=> cpu_rvalid && !cpu_hit && !mem_req);

    p_flush_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !cpu_rvalid && !mem_req);

    p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_busy && !mem_valid |=> !cpu_rvalid);

endmodule

bind assoc_rd_cache assoc_rd_cache_chk #(
    .WAYS   (WAYS),
    .WADDR_W(WADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .cpu_req   (cpu_req),
    .cpu_busy  (cpu_busy),
    .cpu_rvalid(cpu_rvalid),
    .cpu_hit   (cpu_hit),
    .mem_req   (mem_req),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .hit_vec   (hit_vec)
);

// File: tb/assoc_rd_cache_tb_top.sv
`timescale 1ns/1ps
module assoc_rd_cache_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    int         n_vec = 0;
    int         n_bad = 0;
    logic [2:0] lane_done = '0;

    always #10 clk = ~clk;

    function automatic logic [31:0] memfn(input logic [29:0] w);
        return ({2'b00, w} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] mk(input int t, input int s, input int o);
        logic [31:0] a;
        a = {t[21:0], s[7:0], o[1:0]};
        return a;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    generate
        for (genvar g = 0; g < 3; g++) begin : lane
            localparam cache_pkg::repl_e LP = (g == 0) ? cache_pkg::REPL_LRU :
                                              (g == 1) ? cache_pkg::REPL_FIFO :
                                                         cache_pkg::REPL_RANDOM;
            logic        cpu_req = 1'b0;
            logic        flush = 1'b0;
            logic        mem_valid = 1'b0;
            logic [31:0] cpu_addr = '0;
            logic [31:0] mem_rdata = '0;
            logic        busy, rvalid, hit, mem_req;
            logic [31:0] rdata;
            logic [29:0] mem_addr;
            string       cur = "R11";

            assoc_rd_cache #(.POLICY(LP)) dut_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .flush     (flush),
                .cpu_req   (cpu_req),
                .cpu_addr  (cpu_addr),
                .cpu_busy  (busy),
                .cpu_rvalid(rvalid),
                .cpu_hit   (hit),
                .cpu_rdata (rdata),
                .mem_req   (mem_req),
                .mem_addr  (mem_addr),
                .mem_valid (mem_valid),
                .mem_rdata (mem_rdata)
            );

            // ---------------- behavioural reference model ----------------
            bit          mv [256][4];
            logic [21:0] mt [256][4];
            int          recency [256][$];   // most recent first
            int          order   [256][$];   // oldest fill first
            logic [15:0] mlfsr;
            bit          pend;
            logic [29:0] pend_addr;
            int          pend_way;
            bit          e_rvalid, e_hit;
            logic [31:0] e_data;

            task automatic mreset();
                for (int s = 0; s < 256; s++) begin
                    recency[s].delete();
                    order[s].delete();
                    for (int w = 0; w < 4; w++) begin
                        mv[s][w] = 1'b0;
                        recency[s].push_back(w);
                    end
                end
                mlfsr = 16'hACE1;
                pend  = 1'b0;
            endtask

            task automatic touch(input int s, input int w);
                for (int i = 0; i < recency[s].size(); i++)
                    if (recency[s][i] == w) begin
                        recency[s].delete(i);
                        break;
                    end
                recency[s].push_front(w);
            endtask

            function automatic int pick(input int s);
                for (int w = 0; w < 4; w++)
                    if (!mv[s][w]) return w;
                if (LP == cache_pkg::REPL_LRU)  return recency[s][3];
                if (LP == cache_pkg::REPL_FIFO) return order[s][0];
                return int'(mlfsr[1:0]);
            endfunction

            always @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mreset();
                    e_rvalid = 1'b0;
                    e_hit    = 1'b0;
                    e_data   = '0;
                end else begin
                    e_rvalid = 1'b0;
                    if (flush) begin
                        mreset();
                    end else if (pend) begin
                        if (mem_valid) begin
                            int s;
                            s = int'(pend_addr[7:0]);
                            mv[s][pend_way] = 1'b1;
                            mt[s][pend_way] = pend_addr[29:8];
                            touch(s, pend_way);
                            if (order[s].size() == 4) void'(order[s].pop_front());
                            order[s].push_back(pend_way);
                            e_rvalid = 1'b1;
                            e_hit    = 1'b0;
                            e_data   = mem_rdata;
                            pend     = 1'b0;
                        end
                    end else if (cpu_req) begin
                        int s, hw;
                        s  = int'(cpu_addr[9:2]);
                        hw = -1;
                        for (int w = 0; w < 4; w++)
                            if (mv[s][w] && mt[s][w] == cpu_addr[31:10]) hw = w;
                        if (hw >= 0) begin
                            e_rvalid = 1'b1;
                            e_hit    = 1'b1;
                            e_data   = memfn(cpu_addr[31:2]);
                            touch(s, hw);
                        end else begin
                            pend      = 1'b1;
                            pend_addr = cpu_addr[31:2];
                            pend_way  = pick(s);
                        end
                    end
                    if (!flush)
                        mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
                end
            end

            // ---------------- comparator, every clock ----------------
            always @(negedge clk) begin
                string t;
                t = rst_n ? cur : "R11";
                check(rvalid === e_rvalid, t, "cpu_rvalid", 64'(rvalid), 64'(e_rvalid));
                if (e_rvalid) begin
                    check(hit === e_hit, t, "cpu_hit", 64'(hit), 64'(e_hit));
                    check(rdata === e_data, t, "cpu_rdata", 64'(rdata), 64'(e_data));
                end
                check(busy === pend, t, "cpu_busy", 64'(busy), 64'(pend));
                check(mem_req === pend, t, "mem_req", 64'(mem_req), 64'(pend));
                if (pend)
                    check(mem_addr === pend_addr, "R3", "mem_addr", 64'(mem_addr), 64'(pend_addr));
            end

            // ---------------- stimulus ----------------
            task automatic rd(input logic [31:0] a, input int lat, input bit poke);
                @(negedge clk);
                cpu_req  = 1'b1;
                cpu_addr = a;
                @(negedge clk);
                cpu_req = 1'b0;
                if (busy) begin
                    for (int i = 0; i < lat; i++) begin
                        if (poke) begin  // R10: request while a miss is open
                            cpu_req  = 1'b1;
                            cpu_addr = a ^ 32'h0040_0000;
                        end
                        @(negedge clk);
                    end
                    cpu_req   = 1'b0;
                    mem_valid = 1'b1;
                    mem_rdata = memfn(a[31:2]);
                    @(negedge clk);
                    mem_valid = 1'b0;
                end
            endtask

            task automatic fill_collide(input logic [31:0] a);
                @(negedge clk);
                cpu_req  = 1'b1;
                cpu_addr = a;
                @(negedge clk);
                cpu_req = 1'b0;
                @(negedge clk);
                mem_valid = 1'b1;
                mem_rdata = memfn(a[31:2]);
                flush     = 1'b1;
                @(negedge clk);
                mem_valid = 1'b0;
                flush     = 1'b0;
                @(negedge clk);
            endtask

            task automatic flush_with_req(input logic [31:0] a);
                @(negedge clk);
                flush    = 1'b1;
                cpu_req  = 1'b1;
                cpu_addr = a;
                @(negedge clk);
                flush   = 1'b0;
                cpu_req = 1'b0;
                @(negedge clk);
            endtask

            initial begin
                string ptag;
                ptag = (g == 0) ? "R6" : (g == 1) ? "R7" : "R8";
                wait (rst_n === 1'b1);
                repeat (2) @(negedge clk);

                cur = "R5";   // empty set fills ways 0..3 in order
                for (int t = 0; t < 4; t++) rd(mk(t, 5, 0), t, 0);

                cur = "R4";   // each of the four ways must be chosen alone
                for (int t = 3; t >= 0; t--) rd(mk(t, 5, 0), 0, 0);

                cur = "R1";   // offset ignored, same tag in another set misses
                rd(mk(2, 5, 3), 0, 0);
                rd(mk(0, 5, 1), 0, 0);
                rd(mk(2, 6, 2), 1, 0);

                cur = "R2";
                rd(mk(1, 5, 0), 0, 0);
                rd(mk(1, 5, 0), 0, 0);

                cur = "R3";
                rd(mk(100, 200, 2), 3, 0);
                rd(mk(101, 200, 0), 0, 0);

                cur = ptag;   // replacement on a full set
                rd(mk(4, 5, 0), 1, 0);
                for (int t = 0; t < 5; t++) rd(mk(t, 5, 0), 1, 0);
                for (int i = 0; i < 80; i++)
                    rd(mk((i * 7 + 3) % 6, 9 + (i % 2), i % 4), i % 3, 0);

                cur = "R10";
                rd(mk(9, 20, 0), 3, 1);
                rd(mk(9, 20, 0) ^ 32'h0040_0000, 1, 0);
                rd(mk(9, 20, 0), 0, 0);

                cur = "R9";   // refill and flush on the same edge
                fill_collide(mk(30, 40, 0));
                rd(mk(30, 40, 0), 1, 0);
                rd(mk(30, 40, 0), 0, 0);
                flush_with_req(mk(30, 40, 0));
                rd(mk(30, 40, 0), 2, 0);
                for (int i = 0; i < 12; i++) rd(mk(i % 6, 5, 0), 1, 0);

                repeat (3) @(negedge clk);
                lane_done[g] = 1'b1;
            end
        end
    endgenerate

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait (lane_done == 3'b111);
        repeat (2) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule